// File: doc/BRIEF.md
# SPI Command Engine Register and Interrupt Unit

This block is the 32-bit memory-mapped control face of a command-driven SPI controller. Software reaches it through a simple valid/ready register port. It can read an identification word and hold the engine in a soft reset. It controls which interrupt causes reach the interrupt line. It feeds 16-bit commands and 8-bit transmit bytes into two internal queues and drains received bytes from a third queue. It can also inspect the oldest received byte without removing it.

The SPI execution logic is outside the block. On the engine side there are plain stream ports: the block presents the queue heads for commands and transmit bytes, takes in received bytes, and takes in sync events. When the engine finishes a tagged sync command, it reports that command's 8-bit tag. The block records the tag and raises a sticky sync interrupt, so software can tell which program has completed. The other three interrupt causes follow queue occupancy: command queue nearly drained, transmit queue nearly drained, and receive queue nearly full.

Top module: `spi_cmd_csr`

## Requirements
- R1: A read of offset 0x00 returns 0x0001_0000 with the default parameters: major version 1 in bits 23:16, minor in 15:8, patch in 7:0. A read of an unmapped offset returns 0.
- R2: `req_ready_o` is always 1. Every request accepted at a clock edge is answered with `rsp_valid_o` high in the following cycle. Read data comes from the state held just before that edge.
- R3: A write to 0xE0 queues bits 15:0 as a command. Commands leave on `cmd_data_o` in the order they were written, one at each edge where `cmd_valid_o` and `cmd_ready_i` are both high. A read of 0xD0 returns the free command slots (4 minus occupancy).
- R4: A write to 0xE4 queues bits 7:0 as a transmit byte. Bytes leave on `tx_data_o` in order under `tx_valid_o`/`tx_ready_i`. A read of 0xD4 returns the free transmit slots (4 minus occupancy).
- R5: Each edge with `rx_valid_i` high queues `rx_data_i`. A read of 0xD8 returns the receive occupancy. A read of 0xE8 returns the oldest byte in bits 7:0 and removes it. A read of 0xEC returns the same byte and leaves the queue unchanged.
- R6: A push into a full queue is dropped and an extra pop from an empty queue does nothing. A read of 0xE8 or 0xEC while the receive queue is empty returns 0.
- R7: The interrupt state read at 0x84 has these bits: bit 0 is high while command occupancy is 1 or less; bit 1 is high while transmit occupancy is 1 or less; bit 2 is high while receive occupancy is 3 or more (depth minus 1). These three bits follow the live occupancy.
- R8: An edge with `sync_valid_i` high copies `sync_id_i` into the register read at 0xC0 and sets interrupt bit 3.
- R9: Writing 1 to bit 3 of 0x84 clears the sync interrupt. A sync event in the same cycle wins over the clear. Writes to bits 2:0 of 0x84 have no effect.
- R10: Offset 0x80 holds a 4-bit interrupt mask. A read of 0x88 returns the interrupt state ANDed with the mask. `irq_o` is high exactly when that masked value is nonzero.
- R11: Writing 1 to bit 0 of 0x40 drives `engine_rst_o` high and empties all three queues. While it is held, queue pushes and sync events are ignored. Writing 0 releases it, and 0x40 reads back the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata_o | output | 32 | Read data |
| engine_rst_o | output | 1 | Soft reset held to the engine |
| cmd_valid_o | output | 1 | Command queue not empty |
| cmd_ready_i | input | 1 | Engine takes the head command |
| cmd_data_o | output | 16 | Head command |
| tx_valid_o | output | 1 | Transmit queue not empty |
| tx_ready_i | input | 1 | Engine takes the head byte |
| tx_data_o | output | 8 | Head transmit byte |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| sync_valid_i | input | 1 | Sync command completed |
| sync_id_i | input | 8 | Tag of the completed sync command |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that every request is answered, which holds because the port never stalls. They also assume that engine-side strobes are single-cycle pulses that any queue state may meet, so the pushes on a full queue and the pops on an empty queue are legal inputs that must simply be absorbed. The bench drives all requests and strobes half a cycle away from the sampling edge. It pulses each strobe for exactly one edge, so the number of pushes and pops it counts matches the number the block sees. It also drives a sync event and a pending clear into the same edge, to exercise the rule that the event wins.

// File: rtl/spi_cmd_csr_pkg.sv
package spi_cmd_csr_pkg;
  typedef enum logic [7:0] {
    OFS_VER   = 8'h00,
    OFS_SRST  = 8'h40,
    OFS_IEN   = 8'h80,
    OFS_IPEND = 8'h84,
    OFS_ISRC  = 8'h88,
    OFS_SYNC  = 8'hC0,
    OFS_CROOM = 8'hD0,
    OFS_TROOM = 8'hD4,
    OFS_RLVL  = 8'hD8,
    OFS_CPUSH = 8'hE0,
    OFS_TPUSH = 8'hE4,
    OFS_RPOP  = 8'hE8,
    OFS_RPEEK = 8'hEC
  } csr_ofs_e;

  localparam int IRQ_W      = 4;
  localparam int IRQ_CMD_AE = 0;
  localparam int IRQ_TX_AE  = 1;
  localparam int IRQ_RX_AF  = 2;
  localparam int IRQ_SYNC   = 3;
  localparam logic [7:0] VER_MAJOR = 8'd1;
endpackage

// File: rtl/csr_fifo.sv
module csr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign do_push = push_i && (cnt_q < CW'(DEPTH));
  assign do_pop  = pop_i && (cnt_q != '0);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wptr_q] <= data_i;
  end

  assign data_o  = mem_q[rptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/csr_irq.sv
module csr_irq
  import spi_cmd_csr_pkg::*;
#(
  parameter int AE_LVL   = 1,
  parameter int RX_DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      cmd_lvl_i,
  input  logic [31:0]      tx_lvl_i,
  input  logic [31:0]      rx_lvl_i,
  input  logic             sync_evt_i,
  input  logic [IRQ_W-1:0] w1c_i,
  input  logic             ien_we_i,
  input  logic [IRQ_W-1:0] ien_wdata_i,
  output logic [IRQ_W-1:0] ien_o,
  output logic [IRQ_W-1:0] pend_o,
  output logic [IRQ_W-1:0] src_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] ien_q;
  logic             sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      if (ien_we_i) ien_q <= ien_wdata_i;
      // set wins over a same-cycle clear
      if (sync_evt_i)              sync_q <= 1'b1;
      else if (w1c_i[IRQ_SYNC])    sync_q <= 1'b0;
    end
  end

  always_comb begin
    pend_o             = '0;
    pend_o[IRQ_CMD_AE] = cmd_lvl_i <= 32'(AE_LVL);
    pend_o[IRQ_TX_AE]  = tx_lvl_i <= 32'(AE_LVL);
    pend_o[IRQ_RX_AF]  = rx_lvl_i >= 32'(RX_DEPTH - 1);
    pend_o[IRQ_SYNC]   = sync_q;
  end

  assign ien_o = ien_q;
  assign src_o = pend_o & ien_q;
  assign irq_o = |src_o;
endmodule

// File: rtl/spi_cmd_csr.sv
module spi_cmd_csr
  import spi_cmd_csr_pkg::*;
#(
  parameter int CMD_DEPTH = 4,
  parameter int TX_DEPTH  = 4,
  parameter int RX_DEPTH  = 4,
  parameter int AE_LVL    = 1,
  parameter logic [7:0] VER_MINOR = 8'd0,
  parameter logic [7:0] VER_PATCH = 8'd0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [7:0]  req_addr_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  output logic        engine_rst_o,
  output logic        cmd_valid_o,
  input  logic        cmd_ready_i,
  output logic [15:0] cmd_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [7:0]  tx_data_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  input  logic        sync_valid_i,
  input  logic [7:0]  sync_id_i,
  output logic        irq_o
);
  localparam int CCW = $clog2(CMD_DEPTH + 1);
  localparam int TCW = $clog2(TX_DEPTH + 1);
  localparam int RCW = $clog2(RX_DEPTH + 1);

  logic acc_wr, acc_rd, srst_q, sync_evt;
  logic [7:0] sync_id_q;
  logic [CCW-1:0] cmd_cnt;
  logic [TCW-1:0] tx_cnt;
  logic [RCW-1:0] rx_cnt;
  logic [31:0] cmd_lvl, tx_lvl, rx_lvl, rd_mux;
  logic [7:0] rx_head;
  logic [IRQ_W-1:0] ien, pend_vec, src_vec, w1c;
  logic unused_wdata;

  assign req_ready_o = 1'b1;
  assign acc_wr = req_valid_i && req_write_i;
  assign acc_rd = req_valid_i && !req_write_i;
  assign engine_rst_o = srst_q;
  assign sync_evt = sync_valid_i && !srst_q;
  assign unused_wdata = ^req_wdata_i[31:16];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srst_q    <= 1'b0;
      sync_id_q <= '0;
    end else begin
      if (acc_wr && req_addr_i == OFS_SRST) srst_q <= req_wdata_i[0];
      if (sync_evt) sync_id_q <= sync_id_i;
    end
  end

  csr_fifo #(.W(16), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk_i, .rst_ni, .clr_i(srst_q),
    .push_i(acc_wr && req_addr_i == OFS_CPUSH && !srst_q),
    .data_i(req_wdata_i[15:0]),
    .pop_i(cmd_ready_i), .data_o(cmd_data_o), .count_o(cmd_cnt));

  csr_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk_i, .rst_ni, .clr_i(srst_q),
    .push_i(acc_wr && req_addr_i == OFS_TPUSH && !srst_q),
    .data_i(req_wdata_i[7:0]),
    .pop_i(tx_ready_i), .data_o(tx_data_o), .count_o(tx_cnt));

  csr_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk_i, .rst_ni, .clr_i(srst_q),
    .push_i(rx_valid_i && !srst_q), .data_i(rx_data_i),
    .pop_i(acc_rd && req_addr_i == OFS_RPOP),
    .data_o(rx_head), .count_o(rx_cnt));

  assign cmd_lvl = 32'(cmd_cnt);
  assign tx_lvl  = 32'(tx_cnt);
  assign rx_lvl  = 32'(rx_cnt);
  assign cmd_valid_o = cmd_cnt != '0;
  assign tx_valid_o  = tx_cnt != '0;

  assign w1c = (acc_wr && req_addr_i == OFS_IPEND) ? req_wdata_i[IRQ_W-1:0] : '0;

  csr_irq #(.AE_LVL(AE_LVL), .RX_DEPTH(RX_DEPTH)) u_irq (
    .clk_i, .rst_ni,
    .cmd_lvl_i(cmd_lvl), .tx_lvl_i(tx_lvl), .rx_lvl_i(rx_lvl),
    .sync_evt_i(sync_evt), .w1c_i(w1c),
    .ien_we_i(acc_wr && req_addr_i == OFS_IEN),
    .ien_wdata_i(req_wdata_i[IRQ_W-1:0]),
    .ien_o(ien), .pend_o(pend_vec), .src_o(src_vec), .irq_o(irq_o));

  always_comb begin
    rd_mux = '0;
    case (req_addr_i)
      OFS_VER:   rd_mux = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
      OFS_SRST:  rd_mux = 32'(srst_q);
      OFS_IEN:   rd_mux = 32'(ien);
      OFS_IPEND: rd_mux = 32'(pend_vec);
      OFS_ISRC:  rd_mux = 32'(src_vec);
      OFS_SYNC:  rd_mux = 32'(sync_id_q);
      OFS_CROOM: rd_mux = 32'(CMD_DEPTH) - cmd_lvl;
      OFS_TROOM: rd_mux = 32'(TX_DEPTH) - tx_lvl;
      OFS_RLVL:  rd_mux = rx_lvl;
      OFS_RPOP, OFS_RPEEK: rd_mux = (rx_cnt != '0) ? 32'(rx_head) : '0;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= acc_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/spi_cmd_csr_chk.sv
module spi_cmd_csr_chk #(
  parameter int CMD_DEPTH = 4,
  parameter int RX_DEPTH  = 4
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        rsp_valid_o,
  input logic        engine_rst_o,
  input logic        cmd_valid_o,
  input logic        tx_valid_o,
  input logic        sync_valid_i,
  input logic [7:0]  sync_id_i,
  input logic [7:0]  sync_id_q,
  input logic [3:0]  pend_vec,
  input logic [31:0] cmd_lvl,
  input logic [31:0] rx_lvl
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R6
  cmd_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_lvl <= 32'(CMD_DEPTH));
  // R6
  rx_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_lvl <= 32'(RX_DEPTH));
  // R8
  sync_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_valid_i && !engine_rst_o) |=> (sync_id_q == $past(sync_id_i)) && pend_vec[3]);
  // R11
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    engine_rst_o |=> !cmd_valid_o && !tx_valid_o);
  // R11
  sync_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (engine_rst_o && sync_valid_i) |=> $stable(sync_id_q));
endmodule

bind spi_cmd_csr spi_cmd_csr_chk #(.CMD_DEPTH(CMD_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .rsp_valid_o(rsp_valid_o), .engine_rst_o(engine_rst_o),
  .cmd_valid_o(cmd_valid_o), .tx_valid_o(tx_valid_o),
  .sync_valid_i(sync_valid_i), .sync_id_i(sync_id_i), .sync_id_q(sync_id_q),
  .pend_vec(pend_vec), .cmd_lvl(cmd_lvl), .rx_lvl(rx_lvl));

// File: tb/spi_cmd_csr_bench.sv
module spi_cmd_csr_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, engine_rst, cmd_valid, tx_valid, irq;
  logic [31:0] rsp_rdata;
  logic [15:0] cmd_data;
  logic [7:0] tx_data;
  logic cmd_ready = 0, tx_ready = 0, rx_valid = 0, sync_valid = 0;
  logic [7:0] rx_data = '0, sync_id = '0;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  spi_cmd_csr u_spi_cmd_csr (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .engine_rst_o(engine_rst),
    .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_data_o(cmd_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .sync_valid_i(sync_valid),
    .sync_id_i(sync_id), .irq_o(irq));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    d = rsp_rdata;
    chk(32'(rsp_valid), 32'd1, "R2 rsp_valid");
    req_valid = 0;
  endtask

  task automatic pulse_cmd_pop();
    @(negedge clk); cmd_ready = 1; @(negedge clk); cmd_ready = 0;
  endtask

  task automatic pulse_tx_pop();
    @(negedge clk); tx_ready = 1; @(negedge clk); tx_ready = 0;
  endtask

  task automatic rx_push(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b; @(negedge clk); rx_valid = 0;
  endtask

  task automatic sync_pulse(input logic [7:0] id);
    @(negedge clk); sync_valid = 1; sync_id = id; @(negedge clk); sync_valid = 0;
  endtask

  task automatic flush();
    wr(8'h40, 1); wr(8'h40, 0);
  endtask

  task automatic t_reset_state();
    chk(32'(irq), 0, "R10 irq after reset");
    chk(32'(engine_rst), 0, "R11 engine_rst after reset");
    chk(32'(cmd_valid), 0, "R3 cmd_valid after reset");
    chk(32'(req_ready), 1, "R2 ready");
    rd(8'h00, rv); chk(rv, 32'h0001_0000, "R1 version");
    rd(8'h10, rv); chk(rv, 0, "R1 unmapped");
  endtask

  task automatic t_cmd();
    rd(8'hD0, rv); chk(rv, 4, "R3 room empty");
    wr(8'hE0, 32'h1234_ABCD); wr(8'hE0, 32'h0000_3001);
    rd(8'hD0, rv); chk(rv, 2, "R3 room two");
    chk(32'(cmd_valid), 1, "R3 cmd_valid");
    chk(32'(cmd_data), 32'hABCD, "R3 head");
    pulse_cmd_pop();
    chk(32'(cmd_data), 32'h3001, "R3 second");
    pulse_cmd_pop();
    chk(32'(cmd_valid), 0, "R3 drained");
    for (int i = 0; i < 6; i++) wr(8'hE0, 32'(16'h0100 + i));
    rd(8'hD0, rv); chk(rv, 0, "R6 cmd full room");
    for (int i = 0; i < 4; i++) begin
      chk(32'(cmd_data), 32'(16'h0100 + i), "R6 cmd order after overflow");
      pulse_cmd_pop();
    end
    pulse_cmd_pop();
    rd(8'hD0, rv); chk(rv, 4, "R6 pop on empty ignored");
  endtask

  task automatic t_tx();
    wr(8'hE4, 32'hFFFF_FF5A); wr(8'hE4, 32'h0000_00C3);
    rd(8'hD4, rv); chk(rv, 2, "R4 tx room");
    chk(32'(tx_data), 32'h5A, "R4 tx head");
    pulse_tx_pop();
    chk(32'(tx_data), 32'hC3, "R4 tx second");
    pulse_tx_pop();
    chk(32'(tx_valid), 0, "R4 tx drained");
  endtask

  task automatic t_rx();
    rx_push(8'h11); rx_push(8'h22); rx_push(8'h33);
    rd(8'hD8, rv); chk(rv, 3, "R5 level");
    rd(8'hEC, rv); chk(rv, 32'h11, "R5 peek");
    rd(8'hD8, rv); chk(rv, 3, "R5 peek keeps level");
    rd(8'hE8, rv); chk(rv, 32'h11, "R5 pop first");
    rd(8'hE8, rv); chk(rv, 32'h22, "R5 pop second");
    rd(8'hE8, rv); chk(rv, 32'h33, "R5 pop third");
    rd(8'hE8, rv); chk(rv, 0, "R6 pop empty reads 0");
    rd(8'hEC, rv); chk(rv, 0, "R6 peek empty reads 0");
    for (int i = 0; i < 6; i++) rx_push(8'(8'hA0 + i));
    rd(8'hD8, rv); chk(rv, 4, "R6 rx full level");
    rd(8'hE8, rv); chk(rv, 32'hA0, "R6 rx oldest kept");
    flush();
  endtask

  task automatic t_flags();
    rd(8'h84, rv); chk(rv, 32'h3, "R7 empty queues");
    wr(8'hE0, 1); wr(8'hE0, 2);
    rx_push(1); rx_push(2); rx_push(3);
    wr(8'hE4, 7);
    rd(8'h84, rv); chk(rv, 32'h6, "R7 cmd two tx one rx three");
    flush();
  endtask

  task automatic t_sync();
    sync_pulse(8'h5A);
    rd(8'hC0, rv); chk(rv, 32'h5A, "R8 sync id");
    rd(8'h84, rv); chk(rv, 32'hB, "R8 sync pending");
    wr(8'h84, 32'h7);
    rd(8'h84, rv); chk(rv, 32'hB, "R9 low bits not clearable");
    wr(8'h84, 32'hFF);
    rd(8'h84, rv); chk(rv, 32'h3, "R9 w1c clears sync");
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h84; req_wdata = 32'h8;
    sync_valid = 1; sync_id = 8'h77;
    @(negedge clk);
    req_valid = 0; req_write = 0; sync_valid = 0;
    rd(8'h84, rv); chk(rv, 32'hB, "R9 set wins over clear");
    rd(8'hC0, rv); chk(rv, 32'h77, "R8 sync id updated");
  endtask

  task automatic t_irq();
    wr(8'h84, 32'h8);
    wr(8'h80, 0);
    chk(32'(irq), 0, "R10 masked");
    wr(8'h80, 32'h1);
    chk(32'(irq), 1, "R10 cmd ae irq");
    rd(8'h88, rv); chk(rv, 32'h1, "R10 source");
    wr(8'h80, 32'h8);
    chk(32'(irq), 0, "R10 sync not pending");
    sync_pulse(8'h01);
    chk(32'(irq), 1, "R10 sync irq");
    rd(8'h88, rv); chk(rv, 32'h8, "R10 source sync");
    wr(8'h84, 32'h8); wr(8'h80, 0);
  endtask

  task automatic t_soft_reset();
    wr(8'hE0, 32'h0AAA); wr(8'hE4, 32'h55);
    wr(8'h40, 1);
    chk(32'(engine_rst), 1, "R11 engine_rst held");
    rd(8'h40, rv); chk(rv, 1, "R11 readback");
    chk(32'(cmd_valid), 0, "R11 cmd flushed");
    chk(32'(tx_valid), 0, "R11 tx flushed");
    wr(8'hE0, 32'h0BBB);
    rd(8'hD0, rv); chk(rv, 4, "R11 push ignored while held");
    sync_pulse(8'h99);
    rd(8'hC0, rv); chk(rv, 32'h01, "R11 sync ignored while held");
    rd(8'h84, rv); chk(rv, 32'h3, "R11 no sync pending while held");
    wr(8'h40, 0);
    chk(32'(engine_rst), 0, "R11 released");
    wr(8'hE0, 32'h0CCC);
    chk(32'(cmd_data), 32'h0CCC, "R11 push after release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_cmd();
    t_tx();
    t_rx();
    t_flags();
    t_sync();
    t_irq();
    t_soft_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule